// File: doc/BRIEF.md
# DMA-Snooping Write-Back Cache Controller

This block is a small direct-mapped write-back data cache. It sits between one processor and a shared memory bus. A DMA engine on that bus moves data between memory and a disk, and the cache watches every one of those transfers. The tag and state store is read through two independent lookup paths. The processor path serves loads and stores. A second, read-only path compares each observed bus address against the cache contents in the same cycle.

Each line holds one data word and has a valid bit and a dirty bit. On a processor miss, a dirty victim is first written back to memory and then the requested word is fetched. Both transfers go out on the memory master port, which uses a request/acknowledge handshake.

When a DMA transfer touches a cached line, the snoop path keeps memory and cache consistent:
- A DMA read that hits a dirty line makes the cache drive the line's data in place of the stale memory word.
- A DMA write that hits a line, clean or dirty, purges that line.
- While the cache itself owns the bus for a fill or a write-back, the snoop path ignores the bus.
- If a snoop and a processor access meet on the same line index in one cycle, the snoop wins and the processor access is retried in the next cycle.

Top module: `snoop_cache`

## Requirements
- R1: After reset every line is invalid, and `cpuReady`, `memReq` and `intvValid` are low. The first processor read of any address therefore needs a memory fill.
- R2: A processor access that hits, with no conflicting snoop, raises `cpuReady` in the same cycle as the request. A read returns the line data on `cpuRdata`, and no memory request is made.
- R3: A processor miss on a clean or invalid line issues one memory read (`memWe`=0) at `cpuAddr`. `memReq` is held until `memAck`, the returned word is installed clean, and the access then completes as a hit.
- R4: A processor miss whose victim line is dirty first issues one memory write (`memWe`=1) of the victim's data, at address {victim tag, index}. Once that write is acknowledged, the fill read follows at once.
- R5: A processor write hit updates the line and marks it dirty, with no bus traffic. The dirty data reaches memory only on a later eviction.
- R6: A snooped DMA read (`snpWe`=0) of an address that is not cached, or that is cached clean, leaves `intvValid` low and changes no line state.
- R7: A snooped DMA read that hits a dirty line raises `intvValid` in the same cycle, with the line's data on `intvData`. The line stays cached and dirty.
- R8: A snooped DMA write (`snpWe`=1) that hits a clean line invalidates it. The next processor access to that address misses and fetches the DMA data.
- R9: A snooped DMA write that hits a dirty line invalidates it without any write-back.
- R10: A snooped DMA write to an address that is not cached changes no line. This includes an address that shares an index with a cached line but has a different tag.
- R11: While `memReq` is high, the bus belongs to the cache, and snoop inputs cause neither intervention nor invalidation.
- R12: When a live snoop and a processor request name the same line index in one cycle, `cpuReady` stays low in that cycle and the snoop's state change is applied first. The access completes in a later cycle.
- R13: Under mixed processor and DMA traffic, every processor read and every DMA read (intervention data when `intvValid` is high, memory data otherwise) returns the most recent value written to that address by either side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor request, held until `cpuReady` |
| cpuWe | input | 1 | 1 = processor store, 0 = load |
| cpuAddr | input | ADDR_W | Processor word address (low IDX_W bits are the index) |
| cpuWdata | input | DATA_W | Store data |
| cpuReady | output | 1 | Access completes this cycle |
| cpuRdata | output | DATA_W | Load data, valid with `cpuReady` |
| memReq | output | 1 | Cache owns the bus and requests a transfer |
| memWe | output | 1 | 1 = write-back, 0 = fill read |
| memAddr | output | ADDR_W | Transfer word address |
| memWdata | output | DATA_W | Write-back data |
| memAck | input | 1 | Memory completes the transfer |
| memRdata | input | DATA_W | Fill data, valid with `memAck` |
| snpValid | input | 1 | A DMA transfer is observed on the bus |
| snpWe | input | 1 | 1 = DMA writes memory, 0 = DMA reads memory |
| snpAddr | input | ADDR_W | Observed DMA word address |
| intvValid | output | 1 | Cache supplies the data for the observed DMA read |
| intvData | output | DATA_W | Data supplied in place of memory |

## Verification
Two situations are hard to reach from the ports because their inputs must coincide in one exact cycle. The first is a snoop that lands on the same index as a processor access in the same cycle. The second is a DMA write that appears while the cache is in the middle of its own fill. Dedicated scenarios drive the snoop and processor inputs at the same falling edge, or wait until `memReq` is observed high before injecting the snoop. Each scenario then probes the affected line with a follow-up processor access and counts the memory fills and write-backs that it causes. A long mixed run of reads and writes over a few aliasing addresses compares every returned word with a shadow copy of the newest data.

// File: rtl/snoop_cache_pkg.sv
package snoop_cache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2
  } ctrl_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cpuWrite;   // write processor data into the hit line
    logic fillWrite;  // install the returned fill word
    logic busOwned;   // cache is master; snoop path is blind
    logic wbSel;      // memory address comes from the victim tag
  } dp_strobe_t;

endpackage

// File: rtl/snoop_cache_dpath.sv
module snoop_cache_dpath
  import snoop_cache_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strobe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              snpValid,
  input  logic              snpWe,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              cpuHit,
  output logic              victimDirty,
  output logic              conflict,
  output logic [DATA_W-1:0] cpuRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              intvValid,
  output logic [DATA_W-1:0] intvData
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  logic              validQ [LINES];
  logic              dirtyQ [LINES];
  logic [TAG_W-1:0]  tagQ   [LINES];
  logic [DATA_W-1:0] dataQ  [LINES];

  logic [IDX_W-1:0] cpuIdx, snpIdx;
  logic [TAG_W-1:0] cpuTag, snpTag;
  logic snpLive, snpHit, purge;

  assign cpuIdx = cpuAddr[IDX_W-1:0];
  assign cpuTag = cpuAddr[ADDR_W-1:IDX_W];
  assign snpIdx = snpAddr[IDX_W-1:0];
  assign snpTag = snpAddr[ADDR_W-1:IDX_W];

  // processor lookup port
  assign cpuHit      = validQ[cpuIdx] && (tagQ[cpuIdx] == cpuTag);
  assign victimDirty = validQ[cpuIdx] && dirtyQ[cpuIdx];
  assign cpuRdata    = dataQ[cpuIdx];

  // snoop lookup port (read-only)
  assign snpLive   = snpValid && !strobe.busOwned;
  assign snpHit    = snpLive && validQ[snpIdx] && (tagQ[snpIdx] == snpTag);
  assign purge     = snpHit && snpWe;
  assign intvValid = snpHit && !snpWe && dirtyQ[snpIdx];
  assign intvData  = dataQ[snpIdx];
  assign conflict  = snpLive && (snpIdx == cpuIdx);

  // bus master address/data
  assign memAddr  = strobe.wbSel ? {tagQ[cpuIdx], cpuIdx} : cpuAddr;
  assign memWdata = dataQ[cpuIdx];

  for (genvar g = 0; g < LINES; g++) begin : gLine
    localparam logic [IDX_W-1:0] LINE_ID = IDX_W'(g);
    logic selCpu, selSnp;
    assign selCpu = (cpuIdx == LINE_ID);
    assign selSnp = (snpIdx == LINE_ID);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ[g] <= 1'b0;
        dirtyQ[g] <= 1'b0;
      end else if (purge && selSnp) begin
        validQ[g] <= 1'b0;
        dirtyQ[g] <= 1'b0;
      end else if (strobe.fillWrite && selCpu) begin
        validQ[g] <= 1'b1;
        dirtyQ[g] <= 1'b0;
      end else if (strobe.cpuWrite && selCpu) begin
        dirtyQ[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (strobe.fillWrite && selCpu) begin
        tagQ[g]  <= cpuTag;
        dataQ[g] <= memRdata;
      end else if (strobe.cpuWrite && selCpu) begin
        dataQ[g] <= cpuWdata;
      end
    end
  end

endmodule

// File: rtl/snoop_cache_ctrl.sv
module snoop_cache_ctrl
  import snoop_cache_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuReq,
  input  logic       cpuWe,
  input  logic       cpuHit,
  input  logic       victimDirty,
  input  logic       conflict,
  input  logic       memAck,
  output dp_strobe_t strobe,
  output logic       cpuReady,
  output logic       memReq,
  output logic       memWe
);
  ctrl_state_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD   = stateQ;
    strobe   = '0;
    cpuReady = 1'b0;
    memReq   = 1'b0;
    memWe    = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (cpuReq && !conflict) begin
          if (cpuHit) begin
            cpuReady        = 1'b1;
            strobe.cpuWrite = cpuWe;
          end else begin
            stateD = victimDirty ? ST_WBACK : ST_FILL;
          end
        end
      end
      ST_WBACK: begin
        memReq          = 1'b1;
        memWe           = 1'b1;
        strobe.wbSel    = 1'b1;
        strobe.busOwned = 1'b1;
        if (memAck) stateD = ST_FILL;
      end
      ST_FILL: begin
        memReq          = 1'b1;
        strobe.busOwned = 1'b1;
        if (memAck) begin
          strobe.fillWrite = 1'b1;
          stateD           = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/snoop_cache.sv
module snoop_cache
  import snoop_cache_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              snpValid,
  input  logic              snpWe,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              intvValid,
  output logic [DATA_W-1:0] intvData
);
  dp_strobe_t strobe;
  logic cpuHit, victimDirty, conflict;

  snoop_cache_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe),
    .cpuHit(cpuHit), .victimDirty(victimDirty), .conflict(conflict),
    .memAck(memAck), .strobe(strobe), .cpuReady(cpuReady),
    .memReq(memReq), .memWe(memWe)
  );

  snoop_cache_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .memRdata(memRdata), .snpValid(snpValid),
    .snpWe(snpWe), .snpAddr(snpAddr), .cpuHit(cpuHit),
    .victimDirty(victimDirty), .conflict(conflict), .cpuRdata(cpuRdata),
    .memAddr(memAddr), .memWdata(memWdata), .intvValid(intvValid),
    .intvData(intvData)
  );

endmodule

// File: rtl/snoop_cache_chk.sv
module snoop_cache_chk #(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReq,
  input logic              cpuWe,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic              cpuReady,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic              snpValid,
  input logic              snpWe,
  input logic [ADDR_W-1:0] snpAddr,
  input logic              intvValid
);
  // R2
  ready_no_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> (cpuReq && !memReq));

  // R3
  req_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> memReq);

  // R4
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && memAck) |=> (memReq && !memWe));

  // R5
  write_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReady && cpuWe) |=> !memReq);

  // R11
  intv_live_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    intvValid |-> (snpValid && !snpWe && !memReq));

  // R12
  same_index_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && !memReq && (snpAddr[IDX_W-1:0] == cpuAddr[IDX_W-1:0])) |-> !cpuReady);

endmodule

bind snoop_cache snoop_cache_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) uChk (
  .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
  .cpuReady(cpuReady), .memReq(memReq), .memWe(memWe), .memAck(memAck),
  .snpValid(snpValid), .snpWe(snpWe), .snpAddr(snpAddr), .intvValid(intvValid)
);

// File: tb/snoop_cache_test.sv
`timescale 1ns/100ps
module snoop_cache_test;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 3;
  localparam int WORDS  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuReq = 1'b0, cpuWe = 1'b0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic [DATA_W-1:0] cpuWdata = '0;
  logic cpuReady;
  logic [DATA_W-1:0] cpuRdata;
  logic memReq, memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWdata;
  logic memAck = 1'b0;
  logic [DATA_W-1:0] memRdata = '0;
  logic snpValid = 1'b0, snpWe = 1'b0;
  logic [ADDR_W-1:0] snpAddr = '0;
  logic [DATA_W-1:0] dmaData = '0;
  logic intvValid;
  logic [DATA_W-1:0] intvData;

  int checks = 0, errors = 0;
  int wbCount = 0, fillCount = 0;
  logic [ADDR_W-1:0] lastWbAddr = '0;
  logic [DATA_W-1:0] lastWbData = '0;
  logic [DATA_W-1:0] mem [WORDS];
  logic [DATA_W-1:0] refMem [WORDS];

  always #2.5 clk = ~clk;

  snoop_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) uut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuReady(cpuReady), .cpuRdata(cpuRdata),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata), .snpValid(snpValid), .snpWe(snpWe),
    .snpAddr(snpAddr), .intvValid(intvValid), .intvData(intvData)
  );

  function automatic logic [DATA_W-1:0] initVal(int i);
    return 32'hC0DE0000 ^ (32'(i) * 32'h00010003);
  endfunction

  // memory and DMA side of the bus
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= initVal(i);
      memAck <= 1'b0;
    end else begin
      memAck <= memReq && !memAck;
      if (memReq && !memAck) begin
        if (memWe) begin
          mem[memAddr] <= memWdata;
          wbCount      <= wbCount + 1;
          lastWbAddr   <= memAddr;
          lastWbData   <= memWdata;
        end else begin
          memRdata  <= mem[memAddr];
          fillCount <= fillCount + 1;
        end
      end
      if (snpValid && snpWe && !memReq) mem[snpAddr] <= dmaData;
    end
  end

  task automatic checkEq(input string req, input string what,
                         input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cpuAccess(input logic we, input logic [ADDR_W-1:0] a,
                           input logic [DATA_W-1:0] wd,
                           output logic [DATA_W-1:0] rd, output int cyc);
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = a; cpuWdata = wd; cyc = 0;
    forever begin
      #1;
      cyc++;
      if (cpuReady) begin
        rd = cpuRdata;
        @(posedge clk);
        break;
      end
      @(posedge clk);
      @(negedge clk);
    end
    #1 cpuReq = 1'b0;
    if (we) refMem[a] = wd;
  endtask

  task automatic dmaRead(input logic [ADDR_W-1:0] a, output logic iv,
                         output logic [DATA_W-1:0] d);
    @(negedge clk);
    snpValid = 1'b1; snpWe = 1'b0; snpAddr = a;
    #1;
    iv = intvValid;
    d  = intvValid ? intvData : mem[a];
    @(posedge clk);
    #1 snpValid = 1'b0;
  endtask

  task automatic dmaWrite(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    snpValid = 1'b1; snpWe = 1'b1; snpAddr = a; dmaData = d;
    @(posedge clk);
    #1 snpValid = 1'b0;
    refMem[a] = d;
  endtask

  task automatic testReset();
    #1;
    checkEq("R1", "cpuReady after reset", 32'(cpuReady), 32'd0);
    checkEq("R1", "memReq after reset", 32'(memReq), 32'd0);
    checkEq("R1", "intvValid after reset", 32'(intvValid), 32'd0);
  endtask

  task automatic testReadMiss();
    logic [DATA_W-1:0] rd; int cyc, f0, w0;
    f0 = fillCount; w0 = wbCount;
    cpuAccess(1'b0, 10'd5, '0, rd, cyc);
    checkEq("R1", "first read needs a fill", 32'(fillCount - f0), 32'd1);
    checkEq("R3", "fill data", rd, initVal(5));
    checkEq("R3", "no write-back on clean miss", 32'(wbCount - w0), 32'd0);
    f0 = fillCount;
    cpuAccess(1'b0, 10'd5, '0, rd, cyc);
    checkEq("R2", "hit latency", 32'(cyc), 32'd1);
    checkEq("R2", "hit without fill", 32'(fillCount - f0), 32'd0);
    checkEq("R2", "hit data", rd, initVal(5));
  endtask

  task automatic testWriteHitEvict();
    logic [DATA_W-1:0] rd; int cyc, f0, w0; logic iv;
    f0 = fillCount; w0 = wbCount;
    cpuAccess(1'b1, 10'd5, 32'hDEAD0005, rd, cyc);
    checkEq("R5", "write hit latency", 32'(cyc), 32'd1);
    checkEq("R5", "write hit bus traffic", 32'(fillCount - f0 + wbCount - w0), 32'd0);
    cpuAccess(1'b0, 10'd5, '0, rd, cyc);
    checkEq("R5", "read after write", rd, 32'hDEAD0005);
    cpuAccess(1'b0, 10'd13, '0, rd, cyc);
    checkEq("R4", "victim write-back count", 32'(wbCount - w0), 32'd1);
    checkEq("R4", "victim address", 32'(lastWbAddr), 32'd5);
    checkEq("R4", "victim data", lastWbData, 32'hDEAD0005);
    checkEq("R4", "fill after write-back", rd, initVal(13));
    dmaRead(10'd5, iv, rd);
    checkEq("R6", "memory now holds written-back data", rd, 32'hDEAD0005);
  endtask

  task automatic testDmaRead();
    logic [DATA_W-1:0] rd; int cyc, w0; logic iv;
    cpuAccess(1'b0, 10'd20, '0, rd, cyc);
    dmaRead(10'd20, iv, rd);
    checkEq("R6", "clean hit no intervention", 32'(iv), 32'd0);
    checkEq("R6", "clean hit memory data", rd, initVal(20));
    dmaRead(10'd100, iv, rd);
    checkEq("R6", "miss no intervention", 32'(iv), 32'd0);
    cpuAccess(1'b1, 10'd20, 32'h0BAD0020, rd, cyc);
    dmaRead(10'd20, iv, rd);
    checkEq("R7", "dirty hit intervenes", 32'(iv), 32'd1);
    checkEq("R7", "intervention data", rd, 32'h0BAD0020);
    w0 = wbCount;
    cpuAccess(1'b0, 10'd28, '0, rd, cyc);
    checkEq("R7", "line still dirty after intervention", 32'(wbCount - w0), 32'd1);
  endtask

  task automatic testDmaWrite();
    logic [DATA_W-1:0] rd; int cyc, f0, w0;
    cpuAccess(1'b0, 10'd40, '0, rd, cyc);
    dmaWrite(10'd40, 32'h11110040);
    f0 = fillCount;
    cpuAccess(1'b0, 10'd40, '0, rd, cyc);
    checkEq("R8", "clean line purged", 32'(fillCount - f0), 32'd1);
    checkEq("R8", "new DMA data seen", rd, 32'h11110040);
    cpuAccess(1'b1, 10'd41, 32'h22220041, rd, cyc);
    dmaWrite(10'd41, 32'h33330041);
    f0 = fillCount; w0 = wbCount;
    cpuAccess(1'b0, 10'd41, '0, rd, cyc);
    checkEq("R9", "dirty purge no write-back", 32'(wbCount - w0), 32'd0);
    checkEq("R9", "dirty purge refills", 32'(fillCount - f0), 32'd1);
    checkEq("R9", "DMA data kept", rd, 32'h33330041);
    cpuAccess(1'b0, 10'd50, '0, rd, cyc);
    dmaWrite(10'd58, 32'h44440058);
    f0 = fillCount;
    cpuAccess(1'b0, 10'd50, '0, rd, cyc);
    checkEq("R10", "other tag same index untouched", 32'(fillCount - f0), 32'd0);
    checkEq("R10", "data unchanged", rd, initVal(50));
  endtask

  task automatic testBusOwned();
    logic [DATA_W-1:0] rd; int cyc, f0;
    cpuAccess(1'b0, 10'd60, '0, rd, cyc);
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = 1'b0; cpuAddr = 10'd3;
    @(negedge clk);
    checkEq("R11", "cache owns bus", 32'(memReq), 32'd1);
    snpValid = 1'b1; snpWe = 1'b1; snpAddr = 10'd60; dmaData = 32'h55550060;
    @(negedge clk);
    snpValid = 1'b0;
    while (!cpuReady) @(negedge clk);
    #1;
    @(posedge clk);
    #1 cpuReq = 1'b0;
    f0 = fillCount;
    cpuAccess(1'b0, 10'd60, '0, rd, cyc);
    checkEq("R11", "own tenure not snooped", 32'(fillCount - f0), 32'd0);
    checkEq("R11", "line data kept", rd, initVal(60));
  endtask

  task automatic testConflict();
    logic [DATA_W-1:0] rd; int cyc, f0;
    cpuAccess(1'b0, 10'd70, '0, rd, cyc);
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = 1'b0; cpuAddr = 10'd70;
    snpValid = 1'b1; snpWe = 1'b0; snpAddr = 10'd30;
    #1;
    checkEq("R12", "stall on same index read snoop", 32'(cpuReady), 32'd0);
    @(negedge clk);
    snpValid = 1'b0;
    #1;
    checkEq("R12", "retry completes", 32'(cpuReady), 32'd1);
    checkEq("R12", "retry data", cpuRdata, initVal(70));
    @(posedge clk);
    #1 cpuReq = 1'b0;
    f0 = fillCount;
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = 1'b0; cpuAddr = 10'd70;
    snpValid = 1'b1; snpWe = 1'b1; snpAddr = 10'd70; dmaData = 32'h66660070;
    #1;
    checkEq("R12", "stall on same index purge", 32'(cpuReady), 32'd0);
    @(negedge clk);
    snpValid = 1'b0;
    refMem[70] = 32'h66660070;
    while (!cpuReady) @(negedge clk);
    #1;
    checkEq("R12", "purge applied before access", cpuRdata, 32'h66660070);
    checkEq("R12", "access refilled", 32'(fillCount - f0), 32'd1);
    @(posedge clk);
    #1 cpuReq = 1'b0;
  endtask

  task automatic testRandom();
    logic [DATA_W-1:0] rd, wd; int cyc; logic iv; int bad;
    bad = 0;
    for (int n = 0; n < 400; n++) begin
      logic [ADDR_W-1:0] a;
      int op;
      a  = ADDR_W'($urandom_range(0, 39));
      op = $urandom_range(0, 3);
      wd = $urandom;
      case (op)
        0: begin
          cpuAccess(1'b0, a, '0, rd, cyc);
          if (rd !== refMem[a]) begin
            bad++;
            checkEq("R13", "random cpu read", rd, refMem[a]);
          end
        end
        1: cpuAccess(1'b1, a, wd, rd, cyc);
        2: begin
          dmaRead(a, iv, rd);
          if (rd !== refMem[a]) begin
            bad++;
            checkEq("R13", "random DMA read", rd, refMem[a]);
          end
        end
        default: dmaWrite(a, wd);
      endcase
    end
    checkEq("R13", "random mismatches", 32'(bad), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) refMem[i] = initVal(i);
    repeat (4) @(posedge clk);
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    testReadMiss();
    testWriteHitEvict();
    testDmaRead();
    testDmaWrite();
    testBusOwned();
    testConflict();
    testRandom();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule